// File: doc/BRIEF.md
# Strobed 4-to-16 Line Decoder with Output Blanking

This block turns a 4-bit binary code into a 16-line one-hot pattern. The code first passes through a capture stage that a strobe controls. While the strobe is high, the stage follows the code input. When the strobe drops, the stage keeps the code it last took, so the selected line stays put while the code input is free to change.

A blanking input drives every output line to its idle level at once. It works only on the output side and leaves the captured code as it is. When blanking is released, the line that was selected before comes back.

A compile-time parameter sets the output polarity. With active-high polarity, the chosen line is 1 and all other lines are 0. With active-low polarity, the chosen line is 0 and all other lines are 1. The capture stage is modelled synchronously: it is a register that loads on each rising clock edge at which the strobe is high.

Top module: `strobe_dec16`

## Requirements
- R1: A synchronous reset clears the captured code to 0. After reset, with blanking low and the strobe low, output line 0 is the active line.
- R2: On each rising clock edge at which `stb` is 1, the captured code takes the value of `sel`. After that edge, the output decodes the new code.
- R3: On a rising clock edge at which `stb` is 0, the captured code keeps its value. A change on `sel` at that edge does not change `dout`.
- R4: After `stb` falls, the output keeps decoding the code taken at the last edge with `stb` high, even when `sel` changes afterwards.
- R5: Code n (`sel[3]` is the most significant bit) makes output bit `dout[n]` the active line. Bit 0 is line 0 and bit 15 is line 15.
- R6: With ACTIVE_HIGH=1 and blanking low, exactly one bit of `dout` is 1 and the other fifteen bits are 0.
- R7: With ACTIVE_HIGH=0 and blanking low, exactly one bit of `dout` is 0 and the other fifteen bits are 1.
- R8: While `inh` is 1, every bit of `dout` is at the idle level: 16'h0000 for active-high and 16'hFFFF for active-low. This holds whatever the value of `sel` or `stb`.
- R9: Blanking does not alter or block the captured code. The code held before blanking, or loaded during blanking while `stb` is high, is decoded as soon as `inh` returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the capture register |
| rst | input | 1 | Synchronous active-high reset; clears the captured code |
| stb | input | 1 | Strobe: 1 = capture `sel` at each edge, 0 = hold |
| inh | input | 1 | Blanking: 1 = all outputs at the idle level |
| sel | input | 4 | Binary code; bit 3 is the most significant |
| dout | output | 16 | Decoded lines; bit n is line n |

## Verification
The checker tests on every clock edge that the output is fully blanked while `inh` is high. It also checks that exactly one line is active when blanking is off, that an edge with the strobe high is followed by the decode of the sampled code, and that the output stays steady across edges with the strobe low.

Some behaviour appears only in the bench's ordered scenarios. These are the falling-strobe freeze while `sel` keeps moving, and the return of the held code after blanking, including a code loaded while blanked. The bench also covers all sixteen codes on both polarities side by side.

// File: rtl/dec16_pkg.sv
package dec16_pkg;

    localparam int unsigned SEL_W = 4;
    localparam int unsigned OUT_N = 1 << SEL_W;

    typedef logic [SEL_W-1:0] code_t;
    typedef logic [OUT_N-1:0] lines_t;

    // datapath bundle between the capture stage and the output stage
    typedef struct packed {
        logic  blank;
        code_t code;
    } dec_req_t;

    function automatic lines_t lines_idle(input bit act_high);
        return act_high ? '0 : '1;
    endfunction

endpackage

// File: rtl/dec16_latch.sv
module dec16_latch
    import dec16_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  stb,
    input  code_t sel,
    output code_t held
);

    code_t held_q;

    // R1: reset clears; R2: load while strobe high; R3/R4: hold otherwise
    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (stb) begin
            held_q <= sel;
        end
    end

    assign held = held_q;

endmodule

// File: rtl/dec16_onehot.sv
module dec16_onehot
    import dec16_pkg::*;
(
    input  code_t  code,
    output lines_t hot
);

    // R5: line n is hot for code n
    for (genvar n = 0; n < OUT_N; n++) begin : g_line
        assign hot[n] = (code == SEL_W'(n));
    end

endmodule

// File: rtl/dec16_drive.sv
module dec16_drive
    import dec16_pkg::*;
#(
    parameter bit ACTIVE_HIGH = 1'b1
) (
    input  logic   blank,
    input  lines_t hot,
    output lines_t lines
);

    localparam lines_t IDLE = lines_idle(ACTIVE_HIGH);

    if (ACTIVE_HIGH) begin : g_pos
        assign lines = blank ? IDLE : hot;
    end else begin : g_neg
        assign lines = blank ? IDLE : ~hot;
    end

endmodule

// File: rtl/strobe_dec16.sv
module strobe_dec16
    import dec16_pkg::*;
#(
    parameter bit ACTIVE_HIGH = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stb,
    input  logic             inh,
    input  logic [SEL_W-1:0] sel,
    output logic [OUT_N-1:0] dout
);

    dec_req_t req;
    code_t    held;
    lines_t   hot;

    dec16_latch u_latch (
        .clk  (clk),
        .rst  (rst),
        .stb  (stb),
        .sel  (sel),
        .held (held)
    );

    // R9: blanking joins only after the capture register
    assign req.code  = held;
    assign req.blank = inh;

    dec16_onehot u_hot (
        .code (req.code),
        .hot  (hot)
    );

    dec16_drive #(.ACTIVE_HIGH(ACTIVE_HIGH)) u_drive (
        .blank (req.blank),
        .hot   (hot),
        .lines (dout)
    );

endmodule

// File: rtl/dec16_chk.sv
module dec16_chk
    import dec16_pkg::*;
#(
    parameter bit ACTIVE_HIGH = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic             stb,
    input logic             inh,
    input logic [SEL_W-1:0] sel,
    input logic [OUT_N-1:0] dout
);

    localparam lines_t IDLE = lines_idle(ACTIVE_HIGH);

    function automatic lines_t want(input code_t c);
        lines_t p;
        p = lines_t'(1) << c;
        return ACTIVE_HIGH ? p : ~p;
    endfunction

    assert_rst_code0_R1: assert property (@(posedge clk)
        rst |=> (inh || dout == want('0)));

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        stb |=> (inh || dout == want($past(sel))));

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!stb && !inh) |=> (inh || $stable(dout)));

    assert_blank_R8: assert property (@(posedge clk) disable iff (rst)
        inh |-> (dout == IDLE));

    if (ACTIVE_HIGH) begin : g_pos
        assert_one_hot_R6: assert property (@(posedge clk) disable iff (rst)
            !inh |-> ($countones(dout) == 1));
    end else begin : g_neg
        assert_one_cold_R7: assert property (@(posedge clk) disable iff (rst)
            !inh |-> ($countones(~dout) == 1));
    end

endmodule

bind strobe_dec16 dec16_chk #(.ACTIVE_HIGH(ACTIVE_HIGH)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .stb  (stb),
    .inh  (inh),
    .sel  (sel),
    .dout (dout)
);

// File: tb/sim_strobe_dec16.sv
module sim_strobe_dec16;

    localparam int CLK_P = 10;

    typedef struct {
        logic [15:0] hi;
        logic [15:0] lo;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stb = 1'b0;
    logic        inh = 1'b0;
    logic [3:0]  sel = 4'd0;
    logic [15:0] dout_hi;
    logic [15:0] dout_lo;

    item_t       q[$];
    logic [3:0]  mdl = 4'd0;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    strobe_dec16 #(.ACTIVE_HIGH(1'b1)) u0 (
        .clk(clk), .rst(rst), .stb(stb), .inh(inh), .sel(sel), .dout(dout_hi)
    );

    strobe_dec16 #(.ACTIVE_HIGH(1'b0)) u1 (
        .clk(clk), .rst(rst), .stb(stb), .inh(inh), .sel(sel), .dout(dout_lo)
    );

    function automatic item_t expect_of(input logic [3:0] c, input logic b, input string t);
        item_t it;
        it.hi  = b ? 16'h0000 : (16'h0001 << c);
        it.lo  = b ? 16'hFFFF : ~(16'h0001 << c);
        it.tag = t;
        return it;
    endfunction

    // driver: one clock step, inputs changed at the falling edge
    task automatic step(input logic s, input logic b, input logic [3:0] c, input string t);
        @(negedge clk);
        rst = 1'b0;
        stb = s;
        inh = b;
        sel = c;
        if (s) mdl = c;
        q.push_back(expect_of(mdl, b, t));
    endtask

    task automatic do_reset(input string t);
        @(negedge clk);
        rst = 1'b1;
        stb = 1'b0;
        inh = 1'b0;
        sel = 4'hA;
        mdl = 4'd0;
        q.push_back(expect_of(mdl, 1'b0, t));
    endtask

    // monitor: compare a quarter period after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                total++;
                if (dout_hi !== it.hi) begin
                    bad++;
                    $display("FAIL %s active-high: got %h want %h", it.tag, dout_hi, it.hi);
                end
                total++;
                if (dout_lo !== it.lo) begin
                    bad++;
                    $display("FAIL %s active-low: got %h want %h", it.tag, dout_lo, it.lo);
                end
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hang want completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1: reset clears code to 0, sel ignored during reset
        do_reset("R1");
        step(1'b0, 1'b0, 4'h7, "R1");

        // R2, R5, R6, R7: every code loaded while strobe high
        for (int n = 0; n < 16; n++) begin
            step(1'b1, 1'b0, 4'(n), "R5");
        end
        step(1'b1, 1'b0, 4'h3, "R2");
        step(1'b1, 1'b0, 4'hC, "R2");

        // R3: strobe low, sel wanders
        step(1'b0, 1'b0, 4'h1, "R3");
        step(1'b0, 1'b0, 4'hF, "R3");
        step(1'b0, 1'b0, 4'h0, "R3");

        // R4: capture 9, then strobe falls while sel moves
        step(1'b1, 1'b0, 4'h9, "R4");
        step(1'b0, 1'b0, 4'h3, "R4");
        step(1'b0, 1'b0, 4'h6, "R4");

        // R8: blanking with strobe low and high
        step(1'b0, 1'b1, 4'hE, "R8");
        step(1'b1, 1'b1, 4'h5, "R8");
        step(1'b1, 1'b1, 4'hB, "R8");

        // R9: code loaded during blanking appears after release
        step(1'b0, 1'b0, 4'h2, "R9");
        step(1'b0, 1'b1, 4'h4, "R9");
        step(1'b0, 1'b0, 4'h8, "R9");

        // R6/R7 again on edge codes
        step(1'b1, 1'b0, 4'hF, "R6");
        step(1'b1, 1'b0, 4'h0, "R7");

        // R1: reset mid-run, then hold shows code 0
        do_reset("R1");
        step(1'b0, 1'b0, 4'hD, "R1");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule